// File: doc/BRIEF.md
# Reset and limp-home supervisor

This block supervises system reset for a power-management companion chip. It watches the sampled level of a shared, bidirectional active-low reset pin. An external reset request is accepted only after the pin has stayed low for a programmable number of clock cycles. When the chip raises a reset of its own, the block pulls the pin low for a pulse. The pulse is short or long, depending on what caused the reset and on a board strap input.

The block also keeps three software-visible control bits and drives two outputs from them. The enable bit drives a general-purpose enable output, which is gated by the operating mode. The warning bit and the latch bit form a two-stage limp-home mechanism. A reset raises the warning. A second reset that arrives before software has cleared the warning sets the latch, and the latch drives the active-low limp output. While the chip is in its over-temperature mode, the latch is held set. Decoding of the register map, the serial transport and the analog pin drivers sit outside the block; it sees only write strobes and the sampled pin level.

Top module: `rst_limp_supervisor`

## Requirements
- R1: An external reset is accepted only when `pin_level_i` is sampled low on FILT_W consecutive clock edges while the filter is armed. A shorter low period has no effect on any output or control bit.
- R2: Each internal reset event (`uv_evt_i`, `pwron_evt_i`, `otp_exit_evt_i`, `other_evt_i`) makes `pin_pull_o` go high for a pulse. An accepted external reset does not produce a pulse.
- R3: For an undervoltage, power-on or over-temperature-exit event, the pulse lasts SHORT_W cycles when `short_strap_i` is 1 and LONG_W cycles when it is 0.
- R4: For an event that is only `other_evt_i`, the pulse lasts SHORT_W cycles, whatever the value of `short_strap_i`.
- R5: The filter is disarmed while `pin_pull_o` is high. It re-arms only after `pin_level_i` reads high. The block's own pulse therefore never counts as an external reset, and one long external low is accepted only once.
- R6: The enable bit is written from `en_val_i` when `en_wr_i` is high. One cycle later, `en_o` is high exactly when the enable bit is 1 and bit 1 of `mode_i` is 1, which covers mode codes 2'b10 and 2'b11.
- R7: Any system reset, internal or external, clears the enable bit and drives `en_o` low until software writes the bit again.
- R8: Every system reset sets `warn_o`. If `warn_o` was already 1 when that reset arrived, the reset also sets `latch_o`.
- R9: `limp_n_o` is low exactly when `latch_o` is 1.
- R10: While `overtemp_i` is 1, `latch_o` is forced to 1 and `latch_clr_i` is ignored.
- R11: `warn_clr_i` clears `warn_o`. `latch_clr_i` clears `latch_o` when not in over-temperature mode. A system reset in the same cycle as a clear or an enable write takes priority over it.
- R12: After `rst`, `pin_pull_o`, `en_o`, `warn_o` and `latch_o` are 0 and `limp_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level_i | input | 1 | Sampled level of the shared reset pin |
| uv_evt_i | input | 1 | Main-supply undervoltage reset strobe |
| pwron_evt_i | input | 1 | Power-on (leaving Off) reset strobe |
| otp_exit_evt_i | input | 1 | Leaving over-temperature mode reset strobe |
| other_evt_i | input | 1 | Watchdog or other reset strobe |
| overtemp_i | input | 1 | Over-temperature mode flag |
| mode_i | input | 2 | Operating mode code |
| en_wr_i | input | 1 | Enable bit write strobe |
| en_val_i | input | 1 | Value written to the enable bit |
| warn_clr_i | input | 1 | Clear strobe for the warning bit |
| latch_clr_i | input | 1 | Clear strobe for the latch bit |
| short_strap_i | input | 1 | 1 selects the short pulse for strap-dependent causes |
| pin_pull_o | output | 1 | High while the block pulls the reset pin low |
| en_o | output | 1 | Enable output |
| limp_n_o | output | 1 | Active-low limp output |
| warn_o | output | 1 | Warning bit readback |
| latch_o | output | 1 | Latch bit readback |

## Verification
The assertions assume that event strobes last one cycle each. They also assume that `pin_level_i` reads low whenever `pin_pull_o` is high, as it would on a real open-drain pin. The bench meets the second assumption by building the pin level as the wired AND of its own pull-down and the design's pull. It meets the first by driving every event as a single-cycle strobe, set and cleared on falling edges. Mode, strap and over-temperature inputs change only between scenarios. Pulse widths are measured once any earlier pulse has ended, so a restarted pulse never shows up in a width check.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef struct packed {
    logic uv;
    logic pwron;
    logic otp_exit;
    logic other;
  } rst_evt_t;

  function automatic logic strap_cause(input rst_evt_t e);
    return e.uv | e.pwron | e.otp_exit;
  endfunction
endpackage

// File: rtl/rls_ext_filter.sv
module rls_ext_filter #(
  parameter int FILT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_level_i,
  input  logic drive_i,
  output logic ext_evt_o
);
  localparam int CW = (FILT_W > 2) ? $clog2(FILT_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_W - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      cnt       <= '0;
      ext_evt_o <= 1'b0;
    end else begin
      ext_evt_o <= 1'b0;
      if (!armed || drive_i) begin
        cnt   <= '0;
        armed <= pin_level_i && !drive_i;
      end else if (pin_level_i) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        ext_evt_o <= 1'b1;
        armed     <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  pin_high_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    pin_level_i |=> !ext_evt_o);
  // R5
  drive_blocks_filter_chk: assert property (@(posedge clk) disable iff (rst)
    drive_i |=> !ext_evt_o);
endmodule

// File: rtl/rls_pulse_gen.sv
module rls_pulse_gen
  import rls_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  rst_evt_t evt_i,
  input  logic     short_strap_i,
  output logic     drive_o
);
  localparam int CW = $clog2(LONG_W + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_W - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_W - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load;
  logic          any_evt;

  assign any_evt = |evt_i;
  assign load    = (strap_cause(evt_i) && !short_strap_i) ? LONG_LD : SHORT_LD;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o <= 1'b0;
      cnt     <= '0;
    end else if (any_evt) begin
      drive_o <= 1'b1;
      if (!drive_o || load > cnt) cnt <= load;
    end else if (drive_o) begin
      if (cnt == '0) drive_o <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R2
  no_pulse_without_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!drive_o && !any_evt) |=> !drive_o);
  // R2
  evt_starts_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> drive_o);
  // R4
  other_only_short_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i == 4'b0001 && !drive_o) |=> (cnt == SHORT_LD));
endmodule

// File: rtl/rls_ctrl_regs.sv
module rls_ctrl_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       sysrst_i,
  input  logic       overtemp_i,
  input  logic [1:0] mode_i,
  input  logic       en_wr_i,
  input  logic       en_val_i,
  input  logic       warn_clr_i,
  input  logic       latch_clr_i,
  output logic       en_o,
  output logic       limp_n_o,
  output logic       warn_o,
  output logic       latch_o
);
  logic en_bit;
  logic en_nxt, warn_nxt, latch_nxt;

  always_comb begin
    en_nxt    = en_bit;
    warn_nxt  = warn_o;
    latch_nxt = latch_o;
    if (sysrst_i) begin
      en_nxt    = 1'b0;
      warn_nxt  = 1'b1;
      latch_nxt = latch_o | warn_o;
    end else begin
      if (en_wr_i)     en_nxt    = en_val_i;
      if (warn_clr_i)  warn_nxt  = 1'b0;
      if (latch_clr_i) latch_nxt = 1'b0;
    end
    if (overtemp_i) latch_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_bit   <= 1'b0;
      en_o     <= 1'b0;
      warn_o   <= 1'b0;
      latch_o  <= 1'b0;
      limp_n_o <= 1'b1;
    end else begin
      en_bit   <= en_nxt;
      en_o     <= en_nxt & mode_i[1];
      warn_o   <= warn_nxt;
      latch_o  <= latch_nxt;
      limp_n_o <= !latch_nxt;
    end
  end

  // R6
  mode_gates_en_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_i[1] |=> !en_o);
  // R7
  reset_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
    sysrst_i |=> (!en_o && !en_bit));
  // R8
  escalate_chk: assert property (@(posedge clk) disable iff (rst)
    (sysrst_i && warn_o) |=> latch_o);
  // R8
  reset_sets_warn_chk: assert property (@(posedge clk) disable iff (rst)
    sysrst_i |=> warn_o);
  // R10
  overtemp_holds_chk: assert property (@(posedge clk) disable iff (rst)
    overtemp_i |=> (latch_o && !limp_n_o));
endmodule

// File: rtl/rst_limp_supervisor.sv
module rst_limp_supervisor
  import rls_pkg::*;
#(
  parameter int FILT_W  = 8,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_level_i,
  input  logic       uv_evt_i,
  input  logic       pwron_evt_i,
  input  logic       otp_exit_evt_i,
  input  logic       other_evt_i,
  input  logic       overtemp_i,
  input  logic [1:0] mode_i,
  input  logic       en_wr_i,
  input  logic       en_val_i,
  input  logic       warn_clr_i,
  input  logic       latch_clr_i,
  input  logic       short_strap_i,
  output logic       pin_pull_o,
  output logic       en_o,
  output logic       limp_n_o,
  output logic       warn_o,
  output logic       latch_o
);
  rst_evt_t evt;
  logic     ext_evt;
  logic     sysrst;

  assign evt    = '{uv: uv_evt_i, pwron: pwron_evt_i,
                    otp_exit: otp_exit_evt_i, other: other_evt_i};
  assign sysrst = (|evt) | ext_evt;

  rls_ext_filter #(.FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst(rst), .pin_level_i(pin_level_i),
    .drive_i(pin_pull_o), .ext_evt_o(ext_evt));

  rls_pulse_gen #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_pulse (
    .clk(clk), .rst(rst), .evt_i(evt), .short_strap_i(short_strap_i),
    .drive_o(pin_pull_o));

  rls_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .sysrst_i(sysrst), .overtemp_i(overtemp_i),
    .mode_i(mode_i), .en_wr_i(en_wr_i), .en_val_i(en_val_i),
    .warn_clr_i(warn_clr_i), .latch_clr_i(latch_clr_i),
    .en_o(en_o), .limp_n_o(limp_n_o), .warn_o(warn_o), .latch_o(latch_o));

  // R9
  limp_follows_latch_chk: assert property (@(posedge clk) disable iff (rst)
    limp_n_o == !latch_o);
endmodule

// File: tb/tb_rst_limp_supervisor.sv
module tb_rst_limp_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int FILT_W  = 8;
  localparam int SHORT_W = 16;
  localparam int LONG_W  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pull = 1'b0;
  logic uv = 0, pwr = 0, otx = 0, oth = 0, ovt = 0;
  logic [1:0] mode = 2'b00;
  logic en_wr = 0, en_val = 0, warn_clr = 0, latch_clr = 0, strap = 0;
  logic pin_pull, en, limp_n, warn, latch;
  logic pin_level;
  int vec = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pin_level = !(ext_pull || pin_pull);

  rst_limp_supervisor #(.FILT_W(FILT_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) dut (
    .clk(clk), .rst(rst), .pin_level_i(pin_level),
    .uv_evt_i(uv), .pwron_evt_i(pwr), .otp_exit_evt_i(otx), .other_evt_i(oth),
    .overtemp_i(ovt), .mode_i(mode), .en_wr_i(en_wr), .en_val_i(en_val),
    .warn_clr_i(warn_clr), .latch_clr_i(latch_clr), .short_strap_i(strap),
    .pin_pull_o(pin_pull), .en_o(en), .limp_n_o(limp_n), .warn_o(warn), .latch_o(latch));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic v);
    en_wr = 1; en_val = v; step(1); en_wr = 0;
  endtask

  task automatic clr_bits();
    warn_clr = 1; latch_clr = 1; step(1); warn_clr = 0; latch_clr = 0; step(1);
  endtask

  task automatic pulse_width(input logic [3:0] e, input logic s, input int exp, input string tag);
    int w;
    strap = s;
    {uv, pwr, otx, oth} = e;
    step(1);
    {uv, pwr, otx, oth} = 4'b0;
    w = 0;
    while (pin_pull && w < 500) begin w++; step(1); end
    chk(tag, w, exp);
    step(2);
    clr_bits();
  endtask

  task automatic t_reset();
    chk("R12 pull", pin_pull, 0);
    chk("R12 en", en, 0);
    chk("R12 warn", warn, 0);
    chk("R12 latch", latch, 0);
    chk("R12 limp_n", limp_n, 1);
  endtask

  task automatic t_enable();
    mode = 2'b10; wr_en(1); chk("R6 mode10", en, 1);
    mode = 2'b01; step(1); chk("R6 mode01", en, 0);
    mode = 2'b11; step(1); chk("R6 mode11", en, 1);
    mode = 2'b00; step(1); chk("R6 mode00", en, 0);
    mode = 2'b11; step(1); chk("R6 back11", en, 1);
    wr_en(0); chk("R6 write0", en, 0);
    wr_en(1); chk("R6 write1", en, 1);
  endtask

  task automatic t_glitch();
    ext_pull = 1; step(FILT_W - 1); ext_pull = 0; step(3);
    chk("R1 glitch warn", warn, 0);
    chk("R1 glitch en", en, 1);
  endtask

  task automatic t_ext();
    int seen = 0;
    ext_pull = 1;
    for (int i = 0; i < 3*FILT_W; i++) begin step(1); if (pin_pull) seen = 1; end
    ext_pull = 0; step(3);
    chk("R1 ext warn", warn, 1);
    chk("R5 single accept latch", latch, 0);
    chk("R7 ext clears en", en, 0);
    chk("R2 no pulse on external", seen, 0);
    step(2); chk("R7 en stays low", en, 0);
    warn_clr = 1; step(1); warn_clr = 0;
    chk("R11 warn cleared", warn, 0);
  endtask

  task automatic t_widths();
    pulse_width(4'b1000, 0, LONG_W,  "R3 uv strap0");
    pulse_width(4'b1000, 1, SHORT_W, "R3 uv strap1");
    pulse_width(4'b0100, 0, LONG_W,  "R3 pwron strap0");
    pulse_width(4'b0010, 0, LONG_W,  "R3 otp exit strap0");
    pulse_width(4'b0010, 1, SHORT_W, "R3 otp exit strap1");
    pulse_width(4'b0001, 0, SHORT_W, "R4 other strap0");
    pulse_width(4'b0001, 1, SHORT_W, "R4 other strap1");
  endtask

  task automatic t_no_self_trigger();
    strap = 1; oth = 1; step(1); oth = 0;
    step(SHORT_W + FILT_W + 4);
    chk("R5 warn after own pulse", warn, 1);
    chk("R5 no retrigger latch", latch, 0);
  endtask

  task automatic t_escalate();
    oth = 1; step(1); oth = 0;
    chk("R8 latch set", latch, 1);
    chk("R9 limp low", limp_n, 0);
    step(SHORT_W + 3);
    latch_clr = 1; step(1); latch_clr = 0;
    chk("R11 latch cleared", latch, 0);
    chk("R9 limp high", limp_n, 1);
    warn_clr = 1; step(1); warn_clr = 0;
    chk("R11 warn cleared again", warn, 0);
  endtask

  task automatic t_overtemp();
    ovt = 1; step(1);
    chk("R10 latch forced", latch, 1);
    chk("R10 limp low", limp_n, 0);
    latch_clr = 1; step(1); latch_clr = 0;
    chk("R10 clear ignored", latch, 1);
    ovt = 0; step(1);
    chk("R10 held after exit", latch, 1);
    latch_clr = 1; step(1); latch_clr = 0;
    chk("R10 clear after exit", latch, 0);
  endtask

  task automatic t_priority();
    wr_en(1); chk("R6 en before", en, 1);
    oth = 1; warn_clr = 1; en_wr = 1; en_val = 1; step(1);
    oth = 0; warn_clr = 0; en_wr = 0;
    chk("R11 reset beats warn clear", warn, 1);
    chk("R11 reset beats en write", en, 0);
    step(SHORT_W + 3);
    clr_bits();
  endtask

  initial begin
    step(3); rst = 0; step(2);
    t_reset();
    t_enable();
    t_glitch();
    t_ext();
    t_widths();
    t_no_self_trigger();
    t_escalate();
    t_overtemp();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; vec++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule